// File: doc/BRIEF.md
# Two-Stage Triggered Binary Pixel Readout Buffer

This block is the digital periphery of a binary pixel matrix. Each pixel keeps up to two pending hits. Every pending hit has its own 8-bit age counter. A pending hit that reaches the programmed latency in the same cycle as a first-level (L1) trigger sets its bit in an event frame. A pending hit that reaches the latency with no L1 in that cycle is discarded. On every accepted L1 the whole frame goes into a small multi-event buffer. There it waits for a second-level (L2) decision.

L2 decisions are matched to buffered frames in the order their L1 triggers arrived. A reject drops a frame without any output. An accept sends the frame out row by row, one parallel word per row, with an end-of-event flag on the last word. A fast-OR output flags pixel activity for diagnostics. A saturating counter records hits that were lost because both of a pixel's slots were busy.

The matrix size, buffer depth, counter width and fast-OR variant are parameters. The defaults keep the matrix small (32 columns by 16 rows) so that elaboration stays cheap. A full-height matrix is obtained by setting the row count to 256.

Top module: `trig_pixel_buffer`

## Requirements
- R1: A hit strobed at clock edge n is captured by an L1 sampled at edge n+LAT, where LAT is the latency input and a setting of 0 means 256. Pixel p = row*NCOLS + col appears as bit col of the word for that row.
- R2: An L1 sampled one cycle earlier or later than the edge given in R1 does not capture the hit. A hit whose due cycle passes with no L1 is discarded.
- R3: Each pixel holds at most two pending hits. A hit arriving while both slots are busy is dropped, and the overflow count rises by one for each dropped hit, saturating at its maximum.
- R4: Every L1 taken while the buffer is not full stores one frame. The first word of an accepted frame appears one cycle after the accepting L2 edge. The frame then streams out as NROWS consecutive valid words, row 0 first.
- R5: End-of-event is high only on the last word of a frame. Valid is low for at least one cycle between two events.
- R6: An L2 reject removes the oldest undecided frame and produces no output. Decisions apply to frames in L1 order.
- R7: Busy is high while all DEPTH (default 4) buffer entries are occupied. An L1 that arrives while busy stores nothing.
- R8: An L2 pulse is ignored when no undecided frame is buffered. This includes an L2 in the same cycle as the L1 that stores the frame.
- R9: With the registered fast-OR variant (the default), fast-OR is high in the cycle after any hit strobe is high.
- R10: A synchronous reset frees all pending slots, empties the frame buffer and clears the overflow count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Latency clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | NCOLS*NROWS | Per-pixel hit strobes, index row*NCOLS+col |
| l1_i | input | 1 | First-level trigger pulse |
| l2_accept_i | input | 1 | Second-level accept pulse |
| l2_reject_i | input | 1 | Second-level reject pulse |
| latency_i | input | CNT_W | L1 latency in cycles, 0 means 2^CNT_W |
| word_o | output | NCOLS | Readout word, one row |
| valid_o | output | 1 | Readout word valid |
| eoe_o | output | 1 | Last word of an event |
| busy_o | output | 1 | Frame buffer full |
| fast_or_o | output | 1 | Any pixel hit |
| ovf_cnt_o | output | OVF_W | Saturating count of dropped hits |

## Verification
A hit captured at L1 edge E stores the frame at E. An L2 accept sampled at edge E+1 or later, at edge A, puts word 0 on the outputs after edge A+1, and word k after edge A+1+k. After the last word comes one idle cycle. The next accepted event then starts. Busy, the overflow count and fast-OR all follow the edge that causes them by one register.

The bench drives every input at the falling edge and samples at the falling edge, counting edges from the hit strobe. Each read therefore checks a word at exactly the cycle given above. Latency windows are probed one cycle early, on time and one cycle late.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
   typedef enum logic [1:0] {
      DEC_NONE   = 2'd0,
      DEC_ACCEPT = 2'd1,
      DEC_REJECT = 2'd2
   } l2_dec_e;
endpackage

// File: rtl/tpb_pixel_cell.sv
module tpb_pixel_cell #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit,
   input  logic             l1,
   input  logic [CNT_W-1:0] lat,
   output logic             frame_bit,
   output logic             drop
);
   localparam int NSLOT = 2;

   logic [NSLOT-1:0] used_q;
   logic [CNT_W-1:0] age_q [NSLOT];
   logic [NSLOT-1:0] due;
   logic [NSLOT-1:0] take;

   always_comb begin
      for (int s = 0; s < NSLOT; s++) begin
         due[s] = used_q[s] && (age_q[s] == lat);
      end
      take[0]   = hit && !used_q[0];
      take[1]   = hit && used_q[0] && !used_q[1];
      frame_bit = l1 && (|due);
      drop      = hit && (&used_q);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         used_q <= '0;
         for (int s = 0; s < NSLOT; s++) age_q[s] <= '0;
      end else begin
         for (int s = 0; s < NSLOT; s++) begin
            if (due[s]) begin
               used_q[s] <= 1'b0;
            end else if (used_q[s]) begin
               age_q[s] <= age_q[s] + 1'b1;
            end else if (take[s]) begin
               used_q[s] <= 1'b1;
               age_q[s]  <= CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/tpb_l2_queue.sv
module tpb_l2_queue
   import tpb_pkg::*;
#(
   parameter int NCOLS = 32,
   parameter int NROWS = 16,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int RW   = $clog2(NROWS),
   localparam int NPIX = NCOLS * NROWS
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            push,
   input  logic [NPIX-1:0] push_frame,
   input  logic            l2_acc,
   input  logic            l2_rej,
   input  logic            pop,
   input  logic [RW-1:0]   rd_row,
   output logic [NCOLS-1:0] rd_word,
   output l2_dec_e         head_dec,
   output logic [PW:0]     occ,
   output logic            full
);
   logic [NCOLS-1:0] mem [DEPTH*NROWS];
   l2_dec_e          dec_q [DEPTH];
   logic [PW:0]      wptr_q, rptr_q, dptr_q;
   logic [PW-1:0]    widx, ridx, didx;
   logic             undecided;

   always_comb begin
      widx      = wptr_q[PW-1:0];
      ridx      = rptr_q[PW-1:0];
      didx      = dptr_q[PW-1:0];
      occ       = wptr_q - rptr_q;
      full      = (occ == (PW+1)'(DEPTH));
      undecided = (wptr_q != dptr_q);
      head_dec  = (occ != '0) ? dec_q[ridx] : DEC_NONE;
      rd_word   = mem[{ridx, rd_row}];
   end

   always_ff @(posedge clk) begin
      if (push && !full && !rst) begin
         for (int r = 0; r < NROWS; r++) begin
            mem[{widx, RW'(r)}] <= push_frame[r*NCOLS +: NCOLS];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr_q <= '0;
         rptr_q <= '0;
         dptr_q <= '0;
         for (int e = 0; e < DEPTH; e++) dec_q[e] <= DEC_NONE;
      end else begin
         if (push && !full) begin
            dec_q[widx] <= DEC_NONE;
            wptr_q      <= wptr_q + 1'b1;
         end
         if ((l2_acc || l2_rej) && undecided) begin
            dec_q[didx] <= l2_acc ? DEC_ACCEPT : DEC_REJECT;
            dptr_q      <= dptr_q + 1'b1;
         end
         if (pop) rptr_q <= rptr_q + 1'b1;
      end
   end
endmodule

// File: rtl/tpb_row_readout.sv
module tpb_row_readout
   import tpb_pkg::*;
#(
   parameter int NCOLS = 32,
   parameter int NROWS = 16,
   localparam int RW   = $clog2(NROWS)
) (
   input  logic             clk,
   input  logic             rst,
   input  l2_dec_e          head_dec,
   input  logic [NCOLS-1:0] rd_word,
   output logic [RW-1:0]    rd_row,
   output logic             pop,
   output logic [NCOLS-1:0] word_o,
   output logic             valid_o,
   output logic             eoe_o
);
   localparam logic [RW-1:0] LAST_ROW = RW'(NROWS - 1);

   logic [RW-1:0] row_q;
   logic          gap_q;
   logic          sending;

   always_comb begin
      sending = (head_dec == DEC_ACCEPT) && !gap_q;
      rd_row  = row_q;
      pop     = (head_dec == DEC_REJECT) || (sending && (row_q == LAST_ROW));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q   <= '0;
         gap_q   <= 1'b0;
         word_o  <= '0;
         valid_o <= 1'b0;
         eoe_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         eoe_o   <= 1'b0;
         gap_q   <= 1'b0;
         if (sending) begin
            word_o  <= rd_word;
            valid_o <= 1'b1;
            if (row_q == LAST_ROW) begin
               eoe_o <= 1'b1;
               row_q <= '0;
               gap_q <= 1'b1;
            end else begin
               row_q <= row_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/trig_pixel_buffer.sv
module trig_pixel_buffer
   import tpb_pkg::*;
#(
   parameter int NCOLS      = 32,
   parameter int NROWS      = 16,
   parameter int CNT_W      = 8,
   parameter int DEPTH      = 4,
   parameter int OVF_W      = 8,
   parameter bit FASTOR_REG = 1'b1,
   localparam int NPIX      = NCOLS * NROWS,
   localparam int PW        = $clog2(DEPTH),
   localparam int RW        = $clog2(NROWS),
   localparam int SW        = $clog2(NPIX + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NPIX-1:0]  hit_i,
   input  logic             l1_i,
   input  logic             l2_accept_i,
   input  logic             l2_reject_i,
   input  logic [CNT_W-1:0] latency_i,
   output logic [NCOLS-1:0] word_o,
   output logic             valid_o,
   output logic             eoe_o,
   output logic             busy_o,
   output logic             fast_or_o,
   output logic [OVF_W-1:0] ovf_cnt_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (NROWS < 2 || (NROWS & (NROWS - 1)) != 0) begin : g_bad_rows
      $error("NROWS must be a power of two, at least 2");
   end
   if (NCOLS < 1 || CNT_W < 2 || OVF_W < 1) begin : g_bad_width
      $error("NCOLS, CNT_W and OVF_W out of range");
   end

   logic [NPIX-1:0]  frame_vec;
   logic [NPIX-1:0]  drop_vec;
   logic [NCOLS-1:0] q_word;
   logic [RW-1:0]    q_row;
   logic [PW:0]      q_occ;
   l2_dec_e          q_head;
   logic             q_pop;

   for (genvar p = 0; p < NPIX; p++) begin : g_pix
      tpb_pixel_cell #(.CNT_W(CNT_W)) u_cell (
         .clk       (clk),
         .rst       (rst),
         .hit       (hit_i[p]),
         .l1        (l1_i),
         .lat       (latency_i),
         .frame_bit (frame_vec[p]),
         .drop      (drop_vec[p])
      );
   end

   tpb_l2_queue #(.NCOLS(NCOLS), .NROWS(NROWS), .DEPTH(DEPTH)) u_queue (
      .clk        (clk),
      .rst        (rst),
      .push       (l1_i),
      .push_frame (frame_vec),
      .l2_acc     (l2_accept_i),
      .l2_rej     (l2_reject_i),
      .pop        (q_pop),
      .rd_row     (q_row),
      .rd_word    (q_word),
      .head_dec   (q_head),
      .occ        (q_occ),
      .full       (busy_o)
   );

   tpb_row_readout #(.NCOLS(NCOLS), .NROWS(NROWS)) u_readout (
      .clk      (clk),
      .rst      (rst),
      .head_dec (q_head),
      .rd_word  (q_word),
      .rd_row   (q_row),
      .pop      (q_pop),
      .word_o   (word_o),
      .valid_o  (valid_o),
      .eoe_o    (eoe_o)
   );

   localparam logic [OVF_W+SW-1:0] OVF_MAX = {{SW{1'b0}}, {OVF_W{1'b1}}};

   logic [SW-1:0]       drops_n;
   logic [OVF_W+SW-1:0] ovf_sum;
   logic [OVF_W-1:0]    ovf_q;

   always_comb begin
      drops_n = SW'($countones(drop_vec));
      ovf_sum = (OVF_W+SW)'(ovf_q) + (OVF_W+SW)'(drops_n);
   end

   always_ff @(posedge clk) begin
      if (rst)                  ovf_q <= '0;
      else if (ovf_sum > OVF_MAX) ovf_q <= '1;
      else                      ovf_q <= ovf_sum[OVF_W-1:0];
   end
   assign ovf_cnt_o = ovf_q;

   if (FASTOR_REG) begin : g_fast_reg
      logic fast_q;
      always_ff @(posedge clk) begin
         if (rst) fast_q <= 1'b0;
         else     fast_q <= |hit_i;
      end
      assign fast_or_o = fast_q;
   end else begin : g_fast_comb
      assign fast_or_o = |hit_i;
   end
endmodule

// File: rtl/tpb_checker.sv
module tpb_checker #(
   parameter int OVF_W      = 8,
   parameter int OCC_W      = 3,
   parameter int DEPTH      = 4,
   parameter bit FASTOR_REG = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             l1,
   input logic             busy,
   input logic             valid,
   input logic             eoe,
   input logic             fast_or,
   input logic             any_hit,
   input logic [OVF_W-1:0] ovf,
   input logic [OCC_W-1:0] occ
);
   // R10
   rst_clears_chk: assert property (@(posedge clk)
      rst |=> (!busy && !valid && ovf == '0));

   // R5
   eoe_in_valid_chk: assert property (@(posedge clk) disable iff (rst)
      eoe |-> valid);

   // R5
   event_gap_chk: assert property (@(posedge clk) disable iff (rst)
      eoe |=> !valid);

   // R7
   busy_blocks_l1_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && l1) |=> (occ <= $past(occ)));

   // R7
   occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
      occ <= OCC_W'(DEPTH));

   // R3
   ovf_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      ovf >= $past(ovf));

   if (FASTOR_REG) begin : g_fast
      // R9
      fast_or_follow_chk: assert property (@(posedge clk) disable iff (rst)
         fast_or == $past(any_hit));
   end
endmodule

bind trig_pixel_buffer tpb_checker #(
   .OVF_W      (OVF_W),
   .OCC_W      ($clog2(DEPTH) + 1),
   .DEPTH      (DEPTH),
   .FASTOR_REG (FASTOR_REG)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .l1      (l1_i),
   .busy    (busy_o),
   .valid   (valid_o),
   .eoe     (eoe_o),
   .fast_or (fast_or_o),
   .any_hit (|hit_i),
   .ovf     (ovf_cnt_o),
   .occ     (q_occ)
);

// File: tb/tb_trig_pixel_buffer.sv
module tb_trig_pixel_buffer;
   localparam int NCOLS = 32;
   localparam int NROWS = 16;
   localparam int NPIX  = NCOLS * NROWS;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [NPIX-1:0]  hit = '0;
   logic             l1 = 1'b0;
   logic             l2a = 1'b0;
   logic             l2r = 1'b0;
   logic [7:0]       lat = 8'd5;
   logic [NCOLS-1:0] word;
   logic             valid, eoe, busy, fast_or;
   logic [7:0]       ovf;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   trig_pixel_buffer dut (
      .clk (clk), .rst (rst), .hit_i (hit), .l1_i (l1),
      .l2_accept_i (l2a), .l2_reject_i (l2r), .latency_i (lat),
      .word_o (word), .valid_o (valid), .eoe_o (eoe), .busy_o (busy),
      .fast_or_o (fast_or), .ovf_cnt_o (ovf)
   );

   typedef struct packed {
      logic [8:0]  off;
      logic [7:0]  lat;
      logic [15:0] pix;
      logic        hit;
   } vec_t;

   // latency-window table: L1 offset from the hit edge, latency, pixel, captured
   localparam vec_t VT [7] = '{
      '{9'd5,   8'd5,   16'd37,  1'b1},
      '{9'd4,   8'd5,   16'd37,  1'b0},
      '{9'd6,   8'd5,   16'd37,  1'b0},
      '{9'd1,   8'd1,   16'd0,   1'b1},
      '{9'd200, 8'd200, 16'd511, 1'b1},
      '{9'd256, 8'd0,   16'd300, 1'b1},
      '{9'd8,   8'd7,   16'd64,  1'b0}
   };

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic hit_then_l1(input int pix, input int off);
      hit[pix] = 1'b1;
      step();
      hit = '0;
      chk("R9", "fast_or after hit", fast_or, 1);
      repeat (off - 1) step();
      l1 = 1'b1;
      step();
      l1 = 1'b0;
   endtask

   task automatic pulse_acc();
      l2a = 1'b1; step(); l2a = 1'b0;
   endtask

   task automatic pulse_rej();
      l2r = 1'b1; step(); l2r = 1'b0;
   endtask

   task automatic read_event(input logic [NPIX-1:0] expf, input bit lead,
                             input string req);
      if (lead) step();
      for (int r = 0; r < NROWS; r++) begin
         chk(req, "valid", valid, 1);
         chk(req, "word", word, expf[r*NCOLS +: NCOLS]);
         chk("R5", "eoe", eoe, (r == NROWS - 1));
         step();
      end
      chk("R5", "valid gap", valid, 0);
   endtask

   task automatic expect_silent(input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         step();
         if (valid) seen++;
      end
      chk(req, "no output", seen, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [NPIX-1:0] f;
      step(); step(); step();
      // R10 reset state
      chk("R10", "valid", valid, 0);
      chk("R10", "busy", busy, 0);
      chk("R10", "ovf", ovf, 0);
      chk("R9", "fast_or idle", fast_or, 0);
      rst = 1'b0;
      step();

      // R1 / R2 table walk
      for (int v = 0; v < 7; v++) begin
         lat = VT[v].lat;
         step();
         hit_then_l1(int'(VT[v].pix), int'(VT[v].off));
         f = '0;
         if (VT[v].hit) f[VT[v].pix] = 1'b1;
         pulse_acc();
         read_event(f, 1'b1, VT[v].hit ? "R1" : "R2");
      end

      // R3 two slots, third hit dropped
      lat = 8'd50;
      step();
      hit[100] = 1'b1;
      step(); step(); step();
      hit = '0;
      chk("R3", "ovf after third hit", ovf, 1);
      repeat (48) step();
      l1 = 1'b1;
      step(); step();
      l1 = 1'b0;
      f = '0; f[100] = 1'b1;
      pulse_acc();
      read_event(f, 1'b1, "R3");
      pulse_acc();
      read_event('0, 1'b1, "R3");
      chk("R3", "ovf stays", ovf, 1);

      // R6 reject drops oldest, order kept
      lat = 8'd3;
      step();
      hit_then_l1(5, 3);
      hit_then_l1(300, 3);
      pulse_rej();
      pulse_acc();
      f = '0; f[300] = 1'b1;
      read_event(f, 1'b1, "R6");

      // R4 / R5 back-to-back accepted events
      hit_then_l1(17, 3);
      hit_then_l1(511, 3);
      pulse_acc();
      pulse_acc();
      f = '0; f[17] = 1'b1;
      read_event(f, 1'b0, "R4");
      f = '0; f[511] = 1'b1;
      read_event(f, 1'b1, "R4");

      // R7 busy and ignored L1
      l1 = 1'b1;
      repeat (4) step();
      l1 = 1'b0;
      chk("R7", "busy when full", busy, 1);
      l1 = 1'b1; step(); l1 = 1'b0;
      chk("R7", "busy holds", busy, 1);
      l2r = 1'b1;
      repeat (4) step();
      l2r = 1'b0;
      step(); step();
      chk("R7", "busy after drain", busy, 0);
      pulse_acc();
      expect_silent(NROWS + 2, "R7");

      // R8 L2 in the same cycle as the storing L1
      l1 = 1'b1; l2a = 1'b1;
      step();
      l1 = 1'b0; l2a = 1'b0;
      expect_silent(NROWS + 2, "R8");
      pulse_rej();
      step();
      pulse_acc();
      expect_silent(NROWS + 2, "R8");

      // R10 reset clears pending hits, frames and ovf
      lat = 8'd2;
      step();
      hit_then_l1(9, 2);
      lat = 8'd40;
      hit[7] = 1'b1;
      step();
      hit = '0;
      rst = 1'b1;
      step(); step();
      rst = 1'b0;
      chk("R10", "ovf cleared", ovf, 0);
      chk("R10", "busy cleared", busy, 0);
      pulse_acc();
      expect_silent(20, "R10");
      repeat (16) step();
      l1 = 1'b1; step(); l1 = 1'b0;
      pulse_acc();
      read_event('0, 1'b1, "R10");

      finish_run();
   end
endmodule